// File: doc/BRIEF.md
# Slow Clock Source Generator

This block provides a low-rate clock for timers and low-power logic from one of two sources. The first is the fast main clock divided by a fixed factor of two and then by a programmable prescaler, for overall ratios from 2 to 512. The second is an external 32.768 kHz oscillator input. After reset the divided main clock is in use, so a slow clock is always present.

Software asks for the low-speed source through a one-bit select port. The request is honoured only while an activity detector sees that oscillator toggling. The switch uses a two-sided enable handshake, so every pulse on the output is a whole pulse from one source. Once the low-speed source drives the output, the prescaler stops, and a flag tells the power logic that the main oscillator may be turned off. If the low-speed oscillator stops, the block returns to the divided main clock by itself.

Software must keep the prescaler setting such that the slow clock does not exceed 100 kHz. The block does not enforce this.

Top module: `slow_clk_gen`

## Requirements
- R1: After reset `src_lso`, `lso_alive` and `prescaler_idle` are 0, the prescaler value is 0 and `slow_clk` runs at the main clock divided by 2.
- R2: With prescaler value N on the `ps_wr_data` port, the slow clock period is 2×(N+1) main clock cycles, for N from 0 to 255.
- R3: While the low-speed oscillator drives the output, the prescaler is halted and `prescaler_idle` is 1.
- R4: A low-speed request (`sel_wr_data` = 1) made while the low-speed oscillator is not toggling leaves the divided main clock in use (`src_lso` = 0).
- R5: `lso_alive` changes only at the end of a detection window of WIN_CYCLES main cycles. It becomes 1 if that window saw at least two rising edges of `lso_clk`, and 0 otherwise.
- R6: No output phase is shorter than one main clock period, and the two sources are never enabled at the same time.
- R7: With the request set and the oscillator alive, `slow_clk` follows `lso_clk` and `src_lso` is 1. Clearing the request returns the output to the divided main clock with `src_lso` = 0.
- R8: If the low-speed oscillator stops while it is selected, the output returns to the divided main clock without any write.
- R9: A pulse on `ps_wr_en` loads `ps_wr_data` as the new prescaler value, and a pulse on `sel_wr_en` loads bit `sel_wr_data` as the source request (1 = low-speed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Fast main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lso_clk | input | 1 | Low-speed oscillator input |
| ps_wr_en | input | 1 | Prescaler value write strobe |
| ps_wr_data | input | PS_W | Prescaler value N |
| sel_wr_en | input | 1 | Source request write strobe |
| sel_wr_data | input | 1 | Source request, 1 = low-speed |
| slow_clk | output | 1 | Slow clock output |
| src_lso | output | 1 | Low-speed oscillator drives the output |
| lso_alive | output | 1 | Low-speed oscillator seen toggling |
| prescaler_idle | output | 1 | Prescaler halted; main oscillator may stop |

## Verification
The handshake assertions assume that the low-speed oscillator is much slower than the main clock, with several main cycles per half period. They also assume that the source request is not written again before the previous switch has shown up on `src_lso`. The stimulus models the oscillator with a 40 ns period against the 4 ns main clock. It writes a new request only after waiting far longer than one handshake plus one detection window. Random prescaler values are kept small so that period checks stay short, and the extreme setting of 255 is covered by one directed case.

// File: rtl/slow_clk_pkg.sv
`timescale 1ns/1ps
package slow_clk_pkg;
  // total division of the main clock for a prescaler value n
  function automatic int unsigned div_ratio(input int unsigned n);
    return 2 * (n + 1);
  endfunction

  // edges required inside one detection window
  localparam int unsigned MIN_EDGES = 2;
endpackage

// File: rtl/slow_clk_prescaler.sv
`timescale 1ns/1ps
module slow_clk_prescaler #(
  parameter int unsigned PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps_val,
  output logic            div_clk
);
  logic [PS_W-1:0] cnt;
  logic            div_flip;  // half period complete this cycle

  assign div_flip = run && (cnt >= ps_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_clk <= 1'b0;
    end else if (!run) begin
      cnt     <= '0;
      div_clk <= 1'b0;
    end else if (div_flip) begin
      cnt     <= '0;
      div_clk <= ~div_clk;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

  // a halted divider parks its output low
  p_parked_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !div_clk);
endmodule

// File: rtl/slow_clk_toggle_det.sv
`timescale 1ns/1ps
module slow_clk_toggle_det #(
  parameter int unsigned WIN_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lso_clk,
  output logic lso_alive
);
  import slow_clk_pkg::*;
  localparam int unsigned WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;

  logic [2:0]       sync_q;
  logic [WIN_W-1:0] win_cnt;
  logic [1:0]       edge_cnt;
  logic             lso_rise;
  logic             win_end;

  assign lso_rise = sync_q[1] & ~sync_q[2];
  assign win_end  = (win_cnt == WIN_W'(WIN_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      win_cnt   <= '0;
      edge_cnt  <= '0;
      lso_alive <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], lso_clk};
      if (win_end) begin
        win_cnt   <= '0;
        edge_cnt  <= '0;
        lso_alive <= (32'(edge_cnt) + 32'(lso_rise)) >= MIN_EDGES;
      end else begin
        win_cnt <= win_cnt + 1'b1;
        if (lso_rise && edge_cnt != 2'd3) edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  // the verdict moves only at a window boundary
  p_alive_at_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lso_alive) |-> $past(win_end));
endmodule

// File: rtl/slow_clk_glitch_mux.sv
`timescale 1ns/1ps
module slow_clk_glitch_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic lso_clk,
  input  logic lso_alive,
  input  logic want_lso,
  input  logic div_clk,
  output logic slow_clk,
  output logic run_div,
  output logic src_lso
);
  logic want_div;
  logic a_s1, a_s2, en_div;       // divided-clock side
  logic b_s1, b_s2, en_lso;       // low-speed side
  logic m_s1, en_lso_m;           // en_lso seen from main domain
  logic b_rst_n;

  assign want_div = ~want_lso;
  assign b_rst_n  = rst_n & lso_alive;

  // main-domain half of the handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_s1     <= 1'b0;
      a_s2     <= 1'b0;
      m_s1     <= 1'b0;
      en_lso_m <= 1'b0;
    end else begin
      a_s1     <= want_div & ~en_lso;
      a_s2     <= a_s1;
      m_s1     <= en_lso;
      en_lso_m <= m_s1;
    end
  end

  // divided-clock enable moves only on its own falling edge
  always_ff @(negedge div_clk or negedge rst_n) begin
    if (!rst_n) en_div <= 1'b0;
    else        en_div <= a_s2;
  end

  // low-speed side; cleared at once when the oscillator is declared dead
  always_ff @(negedge lso_clk or negedge b_rst_n) begin
    if (!b_rst_n) begin
      b_s1   <= 1'b0;
      b_s2   <= 1'b0;
      en_lso <= 1'b0;
    end else begin
      b_s1   <= want_lso & ~en_div;
      b_s2   <= b_s1;
      en_lso <= b_s2;
    end
  end

  assign run_div  = en_div | (want_div & ~en_lso_m);
  assign slow_clk = (div_clk & en_div) | (lso_clk & en_lso);
  assign src_lso  = en_lso_m;

  p_one_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_div && en_lso));

  p_div_switch_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_div) |-> !div_clk);

  p_lso_needs_alive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_lso |-> lso_alive);

  p_div_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src_lso |-> !div_clk);
endmodule

// File: rtl/slow_clk_gen.sv
`timescale 1ns/1ps
module slow_clk_gen #(
  parameter int unsigned PS_W       = 8,
  parameter int unsigned WIN_CYCLES = 1024
) (
  input  logic            clk_main,
  input  logic            rst_n,
  input  logic            lso_clk,
  input  logic            ps_wr_en,
  input  logic [PS_W-1:0] ps_wr_data,
  input  logic            sel_wr_en,
  input  logic            sel_wr_data,
  output logic            slow_clk,
  output logic            src_lso,
  output logic            lso_alive,
  output logic            prescaler_idle
);
  logic [PS_W-1:0] ps_q;
  logic            sel_q;
  logic            want_lso;
  logic            run_div;
  logic            div_clk;

  // R9: register write ports
  always_ff @(posedge clk_main or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      sel_q <= 1'b0;
    end else begin
      if (ps_wr_en)  ps_q  <= ps_wr_data;
      if (sel_wr_en) sel_q <= sel_wr_data;
    end
  end

  // R4: the request only counts while the oscillator is alive
  assign want_lso       = sel_q & lso_alive;
  assign prescaler_idle = ~run_div;

  slow_clk_toggle_det #(.WIN_CYCLES(WIN_CYCLES)) u_det (
    .clk       (clk_main),
    .rst_n     (rst_n),
    .lso_clk   (lso_clk),
    .lso_alive (lso_alive)
  );

  slow_clk_prescaler #(.PS_W(PS_W)) u_div (
    .clk     (clk_main),
    .rst_n   (rst_n),
    .run     (run_div),
    .ps_val  (ps_q),
    .div_clk (div_clk)
  );

  slow_clk_glitch_mux u_mux (
    .clk       (clk_main),
    .rst_n     (rst_n),
    .lso_clk   (lso_clk),
    .lso_alive (lso_alive),
    .want_lso  (want_lso),
    .div_clk   (div_clk),
    .slow_clk  (slow_clk),
    .run_div   (run_div),
    .src_lso   (src_lso)
  );

  p_request_gated_r7: assert property (@(posedge clk_main) disable iff (!rst_n)
    (!sel_q && !src_lso) |=> !src_lso);
endmodule

// File: tb/test_slow_clk_gen.sv
`timescale 1ns/1ps
module test_slow_clk_gen;
  localparam int unsigned PS_W = 8;
  localparam int unsigned WIN  = 64;
  localparam real TCLK = 4.0;
  localparam real TLSO = 40.0;

  logic clk_main = 1'b0;
  logic rst_n = 1'b0;
  logic lso_clk = 1'b0;
  logic lso_run = 1'b0;
  logic ps_wr_en = 1'b0;
  logic [PS_W-1:0] ps_wr_data = '0;
  logic sel_wr_en = 1'b0;
  logic sel_wr_data = 1'b0;
  logic slow_clk, src_lso, lso_alive, prescaler_idle;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  slow_clk_gen #(.PS_W(PS_W), .WIN_CYCLES(WIN)) i_slow_clk_gen (
    .clk_main(clk_main), .rst_n(rst_n), .lso_clk(lso_clk),
    .ps_wr_en(ps_wr_en), .ps_wr_data(ps_wr_data),
    .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
    .slow_clk(slow_clk), .src_lso(src_lso), .lso_alive(lso_alive),
    .prescaler_idle(prescaler_idle)
  );

  always #2 clk_main = ~clk_main;
  always begin #20; if (lso_run) lso_clk = ~lso_clk; end

  // pulse-width monitor
  logic   mon_on = 1'b0;
  realtime last_t = 0.0;
  realtime min_w = 1.0e9;
  always @(slow_clk) begin
    if (mon_on && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t = $realtime;
  end

  function automatic real exp_div_ns(input int unsigned n);
    return real'((n + 1) * 2) * TCLK;
  endfunction

  task automatic check(input string req, input real act, input real exp);
    n_run++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      n_fail++;
      $display("FAIL %s: actual %0.2f expected %0.2f", req, act, exp);
    end
  endtask

  task automatic measure(output real per);
    realtime t0;
    @(posedge slow_clk);
    @(posedge slow_clk); t0 = $realtime;
    @(posedge slow_clk); per = $realtime - t0;
  endtask

  task automatic write_ps(input int unsigned n);
    @(negedge clk_main); ps_wr_en = 1'b1; ps_wr_data = PS_W'(n);
    @(negedge clk_main); ps_wr_en = 1'b0;
  endtask

  task automatic write_sel(input bit v);
    @(negedge clk_main); sel_wr_en = 1'b1; sel_wr_data = v;
    @(negedge clk_main); sel_wr_en = 1'b0;
  endtask

  task automatic idle_ns(input int unsigned ns);
    #(ns);
    @(negedge clk_main);
  endtask

  initial begin
    real p;
    int unsigned n;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk_main);
    rst_n = 1'b1;
    @(negedge clk_main);
    // R1 reset state
    check("R1 src_lso", real'(src_lso), 0.0);
    check("R1 lso_alive", real'(lso_alive), 0.0);
    check("R1 prescaler_idle", real'(prescaler_idle), 0.0);
    mon_on = 1'b1;
    measure(p); check("R1 period div2", p, exp_div_ns(0));

    // R2 / R9 directed extreme and random prescaler values
    write_ps(255); measure(p); check("R2 N=255", p, exp_div_ns(255));
    for (int i = 0; i < 6; i++) begin
      n = $urandom % 32;
      write_ps(n); measure(p); check("R2 R9 random N", p, exp_div_ns(n));
    end
    write_ps(3);

    // R4 request with dead oscillator
    write_sel(1'b1);
    idle_ns(1200);
    check("R4 src stays div", real'(src_lso), 0.0);
    measure(p); check("R4 period div", p, exp_div_ns(3));

    // R5 / R7 / R3 oscillator starts, request already pending
    lso_run = 1'b1;
    idle_ns(700);
    check("R5 alive", real'(lso_alive), 1.0);
    idle_ns(800);
    check("R7 src_lso", real'(src_lso), 1.0);
    measure(p); check("R7 period lso", p, TLSO);
    check("R3 prescaler idle", real'(prescaler_idle), 1.0);

    // R7 back to divided clock
    write_ps(1);
    write_sel(1'b0);
    idle_ns(800);
    check("R7 src back", real'(src_lso), 0.0);
    check("R3 prescaler running", real'(prescaler_idle), 0.0);
    measure(p); check("R7 period div", p, exp_div_ns(1));

    // R8 oscillator dies while selected
    write_sel(1'b1);
    idle_ns(800);
    check("R8 precondition src_lso", real'(src_lso), 1.0);
    lso_run = 1'b0;
    idle_ns(1500);
    check("R5 alive drops", real'(lso_alive), 0.0);
    check("R8 src fallback", real'(src_lso), 0.0);
    measure(p); check("R8 period div", p, exp_div_ns(1));

    // R6 no runt pulses over the whole run
    n_run++;
    if (min_w < TCLK - 0.01) begin
      n_fail++;
      $display("FAIL R6: actual min width %0.2f expected >= %0.2f", min_w, TCLK);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #150000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule